// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Sequencer

This block pairs two eight-line interrupt request resolvers in a cascade. The upper (master) stage takes request lines 0 to 7, and the lower (slave) stage takes lines 8 to 15. The slave reports into master line 2. The external pin for master line 2 is therefore unused. Whenever the slave holds a pending request, it pulses into master line 2, where it is captured as an edge. The processor request output is high whenever the master holds anything pending.

When the processor strobes an acknowledge, the block works out the winning master line. If that winner is the cascade line, it also picks the slave winner and acknowledges both stages. It then returns an 8-bit vector, formed as the responsible stage's programmed base plus the winning line number. If a stage has nothing to offer, the block returns that stage's spurious vector, which is its base plus 7. A small write port sets the two vector bases and the two per-line trigger-mode registers. Priority is fixed, and the acknowledge works in automatic end-of-interrupt style, so no in-service state is kept.

Top module: `pic_cascade_seq`

## Requirements
- R1: After synchronous reset, `cpu_req` is 0, `vec_valid` is 0, `vec` is 0x00, all bases are 0, and every line is in edge mode.
- R2: An edge-mode line becomes pending on a 0-to-1 transition seen on a clock edge. It stays pending until it is acknowledged. A line held high after its acknowledge does not become pending again.
- R3: A level-mode line is pending exactly while its input is high, registered on each clock. An acknowledge does not clear it.
- R4: Priority within each stage is fixed: the lowest pending line index wins.
- R5: An `ack` strobe sampled on a clock edge produces `vec_valid` high for exactly the following cycle. `vec` is updated at the same time and holds its value until the next acknowledge.
- R6: Any pending slave line makes master line 2 pending on the same clock edge, so `cpu_req` rises one cycle after the slave input rises.
- R7: If master line 2 wins, the slave is acknowledged as well, and `vec` is the slave base plus the slave winner. The slave winner is cleared if it is in edge mode. Master line 2 is cleared, and it is set again at once if the slave still holds a request.
- R8: An acknowledge with nothing pending in the master returns the master base plus 7.
- R9: If master line 2 wins but the slave holds nothing, the acknowledge returns the slave base plus 7.
- R10: Config write selects `cfg_sel` are: 0 = master base, 1 = slave base, 2 = master trigger mode, 3 = slave trigger mode. Bases keep bits 7:3 only, and bits 2:0 are stored as zero.
- R11: Trigger-mode bit n set to 1 selects level mode for line n. Master writes are masked with 0xF8 and slave writes with 0xDE, so master lines 0, 1, 2 and slave lines 0, 5 are always edge mode.
- R12: The external input `irq_lines[2]` has no effect on any output.
- R13: `cpu_req` is high exactly when at least one master line is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 16 | Request inputs; bits 7:0 master, bits 15:8 slave |
| ack | input | 1 | Processor acknowledge strobe, one cycle |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Configuration register select |
| cfg_data | input | 8 | Configuration write data |
| cpu_req | output | 1 | Interrupt request to the processor |
| vec | output | 8 | Vector returned by the last acknowledge |
| vec_valid | output | 1 | One-cycle strobe marking a new vector |

## Verification
A pending bit that is stuck, lost or wrongly set in the master appears on `cpu_req` in the cycle after the input that caused it. A slave pending bit that is wrong only becomes visible through the cascade line. It shows on `cpu_req` once the master is otherwise idle, or in `vec` one cycle after the next acknowledge. A wrong winner, base or clear decision is therefore seen in the vector one cycle after the strobe, and a missed clear is seen as a repeated vector on the following acknowledge. The reference model is compared on every cycle, so any of these divergences is reported at the first cycle it reaches a port.

// File: rtl/pic_cascade_pkg.sv
package pic_cascade_pkg;

    localparam int LINES        = 8;
    localparam int IDX_W        = $clog2(LINES);
    localparam int VEC_W        = 8;
    localparam int CASCADE_LINE = 2;
    localparam int SPUR_LINE    = LINES - 1;

    localparam logic [LINES-1:0] MASTER_TRIG_MASK = 8'hF8;
    localparam logic [LINES-1:0] SLAVE_TRIG_MASK  = 8'hDE;
    localparam logic [VEC_W-1:0] BASE_KEEP_MASK   = ~VEC_W'(LINES - 1);

    typedef logic [LINES-1:0] line_vec_t;
    typedef logic [VEC_W-1:0] vec_t;

    typedef enum logic [1:0] {
        CFG_MASTER_BASE = 2'd0,
        CFG_SLAVE_BASE  = 2'd1,
        CFG_MASTER_TRIG = 2'd2,
        CFG_SLAVE_TRIG  = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic             found;
        logic [IDX_W-1:0] idx;
    } winner_t;

    typedef struct packed {
        vec_t      master_base;
        vec_t      slave_base;
        line_vec_t master_level;
        line_vec_t slave_level;
    } cfg_state_t;

    typedef struct packed {
        line_vec_t master_clr;
        line_vec_t slave_clr;
        vec_t      code;
    } ack_result_t;

    // Lowest set index wins; scanning downward lets the lowest overwrite.
    function automatic winner_t pick_winner(input line_vec_t pend);
        winner_t w;
        w = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (pend[i]) begin
                w.found = 1'b1;
                w.idx   = IDX_W'(i);
            end
        end
        return w;
    endfunction

    function automatic line_vec_t line_bit(input int unsigned idx);
        line_vec_t v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    function automatic vec_t form_vector(input vec_t base, input logic [IDX_W-1:0] idx);
        return base + VEC_W'(idx);
    endfunction

endpackage

// File: rtl/pic_cascade_cfg.sv
module pic_cascade_cfg
    import pic_cascade_pkg::*;
#(
    parameter line_vec_t M_MASK = MASTER_TRIG_MASK,
    parameter line_vec_t S_MASK = SLAVE_TRIG_MASK
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [1:0] sel,
    input  vec_t       data,
    output cfg_state_t cfg
);

    cfg_state_t cfg_q;
    cfg_state_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            unique case (cfg_sel_e'(sel))
                CFG_MASTER_BASE: cfg_d.master_base  = data & BASE_KEEP_MASK;
                CFG_SLAVE_BASE:  cfg_d.slave_base   = data & BASE_KEEP_MASK;
                CFG_MASTER_TRIG: cfg_d.master_level = data[LINES-1:0] & M_MASK;
                CFG_SLAVE_TRIG:  cfg_d.slave_level  = data[LINES-1:0] & S_MASK;
                default:         cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/pic_line_resolver.sv
module pic_line_resolver
    import pic_cascade_pkg::*;
#(
    parameter int N = LINES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] level_mode,
    input  logic [N-1:0] lines,
    input  logic [N-1:0] inject,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend_q,
    output logic [N-1:0] pend_d
);

    logic [N-1:0] prev_q;
    logic [N-1:0] rise;

    assign rise = lines & ~prev_q;

    for (genvar g = 0; g < N; g++) begin : g_line
        always_comb begin
            if (level_mode[g])
                pend_d[g] = lines[g] | inject[g];
            else
                pend_d[g] = (pend_q[g] & ~clr[g]) | rise[g] | inject[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            prev_q <= '0;
        end else begin
            pend_q <= pend_d;
            prev_q <= lines;
        end
    end

    AST_LEVEL_TRACKS_INPUT: assert property (@(posedge clk) disable iff (rst)
        (!rst) |=> ((pend_q & $past(level_mode)) == ($past(lines | inject) & $past(level_mode)))); // R3

    AST_EDGE_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!rst) |=> ((pend_q & $past(clr & ~level_mode & ~rise & ~inject)) == '0)); // R2

endmodule

// File: rtl/pic_ack_decoder.sv
module pic_ack_decoder
    import pic_cascade_pkg::*;
#(
    parameter int CASC  = CASCADE_LINE,
    parameter int SPUR  = SPUR_LINE
) (
    input  logic        ack,
    input  line_vec_t   master_pend,
    input  line_vec_t   slave_pend,
    input  vec_t        master_base,
    input  vec_t        slave_base,
    output ack_result_t result
);

    localparam logic [IDX_W-1:0] CASC_IDX = IDX_W'(CASC);
    localparam logic [IDX_W-1:0] SPUR_IDX = IDX_W'(SPUR);

    winner_t m_win;
    winner_t s_win;

    assign m_win = pick_winner(master_pend);
    assign s_win = pick_winner(slave_pend);

    always_comb begin
        result = '0;
        if (!m_win.found) begin
            result.code = form_vector(master_base, SPUR_IDX);
        end else if (m_win.idx == CASC_IDX) begin
            result.master_clr = line_bit(CASC);
            if (s_win.found) begin
                result.slave_clr = line_bit(32'(s_win.idx));
                result.code      = form_vector(slave_base, s_win.idx);
            end else begin
                result.code      = form_vector(slave_base, SPUR_IDX);
            end
        end else begin
            result.master_clr = line_bit(32'(m_win.idx));
            result.code       = form_vector(master_base, m_win.idx);
        end
        if (!ack) begin
            result.master_clr = '0;
            result.slave_clr  = '0;
        end
    end

endmodule

// File: rtl/pic_cascade_seq.sv
module pic_cascade_seq
    import pic_cascade_pkg::*;
#(
    parameter line_vec_t M_TRIG_MASK = MASTER_TRIG_MASK,
    parameter line_vec_t S_TRIG_MASK = SLAVE_TRIG_MASK,
    parameter int        CASC        = CASCADE_LINE,
    parameter int        SPUR        = SPUR_LINE
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2*LINES-1:0]   irq_lines,
    input  logic                 ack,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_sel,
    input  logic [VEC_W-1:0]     cfg_data,
    output logic                 cpu_req,
    output logic [VEC_W-1:0]     vec,
    output logic                 vec_valid
);

    localparam line_vec_t CASC_BIT = line_bit(CASC);

    cfg_state_t  cfg;
    ack_result_t ack_res;
    line_vec_t   m_pend_q, m_pend_d;
    line_vec_t   s_pend_q, s_pend_d;
    line_vec_t   m_lines, s_lines;
    line_vec_t   m_inject;
    logic        s_any;
    vec_t        vec_q;
    logic        valid_q;

    pic_cascade_cfg #(
        .M_MASK (M_TRIG_MASK),
        .S_MASK (S_TRIG_MASK)
    ) u_cfg (
        .clk  (clk),
        .rst  (rst),
        .we   (cfg_we),
        .sel  (cfg_sel),
        .data (cfg_data),
        .cfg  (cfg)
    );

    // The cascade pin of the master is owned by the slave stage.
    assign m_lines = irq_lines[LINES-1:0] & ~CASC_BIT;
    assign s_lines = irq_lines[2*LINES-1:LINES];

    pic_line_resolver #(.N(LINES)) u_slave (
        .clk        (clk),
        .rst        (rst),
        .level_mode (cfg.slave_level),
        .lines      (s_lines),
        .inject     ('0),
        .clr        (ack_res.slave_clr),
        .pend_q     (s_pend_q),
        .pend_d     (s_pend_d)
    );

    // Forward the slave state after this cycle's acknowledge so that a
    // just-serviced slave line does not leave a stale cascade request.
    assign s_any    = |s_pend_d;
    assign m_inject = s_any ? CASC_BIT : '0;

    pic_line_resolver #(.N(LINES)) u_master (
        .clk        (clk),
        .rst        (rst),
        .level_mode (cfg.master_level),
        .lines      (m_lines),
        .inject     (m_inject),
        .clr        (ack_res.master_clr),
        .pend_q     (m_pend_q),
        .pend_d     (m_pend_d)
    );

    pic_ack_decoder #(
        .CASC (CASC),
        .SPUR (SPUR)
    ) u_ack (
        .ack         (ack),
        .master_pend (m_pend_q),
        .slave_pend  (s_pend_q),
        .master_base (cfg.master_base),
        .slave_base  (cfg.slave_base),
        .result      (ack_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= ack;
            if (ack) vec_q <= ack_res.code;
        end
    end

    assign cpu_req   = |m_pend_q;
    assign vec       = vec_q;
    assign vec_valid = valid_q;

    AST_VALID_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(ack)); // R5

    AST_SPURIOUS_MASTER: assert property (@(posedge clk) disable iff (rst)
        (ack && !cpu_req) |=> (vec == ($past(cfg.master_base) + VEC_W'(SPUR)))); // R8

    AST_SLAVE_FORWARD: assert property (@(posedge clk) disable iff (rst)
        s_any |=> m_pend_q[CASC]); // R6

    AST_VECTOR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!rst && !ack) |=> $stable(vec)); // R5

endmodule

// File: tb/pic_cascade_seq_test.sv
module pic_cascade_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] irq = '0;
    logic        ack = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_data = '0;
    logic        cpu_req;
    logic [7:0]  vec;
    logic        vec_valid;

    int compared = 0;
    int mismatched = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    pic_cascade_seq uut (
        .clk       (clk),
        .rst       (rst),
        .irq_lines (irq),
        .ack       (ack),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_data  (cfg_data),
        .cpu_req   (cpu_req),
        .vec       (vec),
        .vec_valid (vec_valid)
    );

    // Behavioural reference model
    bit   mp[8], sp[8], sprev[8], mprev[8];
    bit   mlev[8], slev[8];
    logic [7:0] mbase, sbase, vec_m;
    bit   valid_m;
    int   mw, sw;
    bit   mclr[8], sclr[8];
    bit   s_any_m, ln, np;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) begin
                mp[i] = 0; sp[i] = 0; sprev[i] = 0; mprev[i] = 0;
                mlev[i] = 0; slev[i] = 0;
            end
            mbase = 0; sbase = 0; vec_m = 0; valid_m = 0;
        end else begin
            mw = -1; sw = -1;
            for (int i = 0; i < 8; i++) begin
                if (mp[i] && mw < 0) mw = i;
                if (sp[i] && sw < 0) sw = i;
                mclr[i] = 0; sclr[i] = 0;
            end
            valid_m = ack;
            if (ack) begin
                if (mw < 0) vec_m = mbase + 8'd7;
                else if (mw == 2) begin
                    mclr[2] = 1;
                    if (sw < 0) vec_m = sbase + 8'd7;
                    else begin
                        sclr[sw] = 1;
                        vec_m = sbase + 8'(sw);
                    end
                end else begin
                    mclr[mw] = 1;
                    vec_m = mbase + 8'(mw);
                end
            end
            s_any_m = 0;
            for (int i = 0; i < 8; i++) begin
                ln = irq[8+i];
                if (slev[i]) np = ln;
                else np = (sp[i] && !sclr[i]) || (ln && !sprev[i]);
                sprev[i] = ln;
                sp[i] = np;
                if (np) s_any_m = 1;
            end
            for (int i = 0; i < 8; i++) begin
                ln = (i == 2) ? 1'b0 : irq[i];
                if (mlev[i]) np = ln || (i == 2 && s_any_m);
                else np = (mp[i] && !mclr[i]) || (ln && !mprev[i]) || (i == 2 && s_any_m);
                mprev[i] = ln;
                mp[i] = np;
            end
            if (cfg_we) begin
                case (cfg_sel)
                    2'd0: mbase = cfg_data & 8'hF8;
                    2'd1: sbase = cfg_data & 8'hF8;
                    2'd2: for (int i = 0; i < 8; i++) mlev[i] = cfg_data[i] & (i >= 3);
                    default: for (int i = 0; i < 8; i++) slev[i] = cfg_data[i] & (i != 0) & (i != 5);
                endcase
            end
        end
    end

    function automatic bit model_req();
        for (int i = 0; i < 8; i++) if (mp[i]) return 1;
        return 0;
    endfunction

    // Cycle compare against the model
    always @(negedge clk) begin
        compared++;
        if ({cpu_req, vec_valid, vec} !== {model_req(), valid_m, vec_m}) begin
            mismatched++;
            $display("FAIL %s cycle compare: act req=%0b valid=%0b vec=%02h exp req=%0b valid=%0b vec=%02h",
                     cur_req, cpu_req, vec_valid, vec, model_req(), valid_m, vec_m);
        end
    end

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s directed: act=%03h exp=%03h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic write_cfg(input logic [1:0] s, input logic [7:0] d);
        cfg_we = 1; cfg_sel = s; cfg_data = d;
        tick(1);
        cfg_we = 0;
    endtask

    // Strobe ack, check vector one cycle later, then check the pulse ended.
    task automatic do_ack(input string req, input logic [7:0] exp);
        ack = 1;
        tick(1);
        ack = 0;
        @(negedge clk);
        check(req, {vec_valid, vec}, {1'b1, exp});
        @(posedge clk); #2;
        @(negedge clk);
        check("R5", {8'd0, vec_valid}, 9'd0);
        @(posedge clk); #2;
    endtask

    task automatic check_req(input string req, input bit exp);
        @(negedge clk);
        check(req, {8'd0, cpu_req}, {8'd0, exp});
        @(posedge clk); #2;
    endtask

    initial begin
        tick(4);
        @(negedge clk);
        check("R1", {cpu_req, vec}, 9'd0);
        check("R1", {8'd0, vec_valid}, 9'd0);
        rst = 0;
        @(posedge clk); #2;

        cur_req = "R10";
        write_cfg(2'd0, 8'h27);
        write_cfg(2'd1, 8'h75);

        cur_req = "R8";
        do_ack("R8", 8'h27);

        cur_req = "R2";
        irq[5] = 1;
        tick(1);
        check_req("R13", 1);
        do_ack("R2", 8'h25);
        tick(1);
        check_req("R2", 0);
        irq[5] = 0;
        tick(1);

        cur_req = "R4";
        irq[6] = 1; irq[3] = 1;
        tick(1);
        do_ack("R4", 8'h23);
        do_ack("R4", 8'h26);
        check_req("R4", 0);
        irq[6] = 0; irq[3] = 0;
        tick(1);

        cur_req = "R6";
        irq[12] = 1;
        tick(1);
        check_req("R6", 1);
        cur_req = "R7";
        do_ack("R7", 8'h74);
        check_req("R7", 0);
        irq[12] = 0;
        irq[9] = 1; irq[14] = 1;
        tick(1);
        do_ack("R7", 8'h71);
        check_req("R7", 1);
        do_ack("R7", 8'h76);
        irq[9] = 0; irq[14] = 0;
        tick(1);

        cur_req = "R12";
        irq[2] = 1;
        tick(3);
        check_req("R12", 0);
        irq[2] = 0;
        tick(1);

        cur_req = "R3";
        write_cfg(2'd2, 8'hFF);
        irq[4] = 1;
        tick(1);
        do_ack("R3", 8'h24);
        check_req("R3", 1);
        irq[4] = 0;
        tick(1);
        check_req("R3", 0);

        cur_req = "R11";
        irq[1] = 1;
        tick(1);
        do_ack("R11", 8'h21);
        check_req("R11", 0);
        irq[1] = 0;
        write_cfg(2'd3, 8'hFF);
        irq[8] = 1;
        tick(1);
        do_ack("R11", 8'h70);
        check_req("R11", 0);
        irq[8] = 0;
        tick(1);

        cur_req = "R9";
        irq[11] = 1;
        tick(2);
        irq[11] = 0;
        tick(2);
        check_req("R9", 1);
        do_ack("R9", 8'h77);
        check_req("R9", 0);

        cur_req = "R13";
        tick(3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL %s watchdog expired: act=running exp=finished", cur_req);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule